// File: doc/BRIEF.md
# Watermark-Terminated FIFO Burst Writer

This block is the master side of a parallel link into an external synchronous slave FIFO. It moves 32-bit words from a local data source onto the bus, one word per clock while its active-low write strobe is low. A burst starts when the target's buffer-available flag, brought in through a register chain, shows that a fresh buffer is ready. The burst does not run until the target reports full. Instead, the target drops an active-low early-warning flag while a small fixed number of words can still be accepted. The writer stops on that flag.

The early-warning flag passes through `SYNC_STAGES` registers, so the writer learns of it late. To compensate, the writer keeps a short history of its own strobes covering that window. When the registered flag shows low, it subtracts the writes already made during the window from the target's remaining room, which is `TRAIL_WORDS + SYNC_STAGES`. It then issues exactly the words that are left. Cycles in which the source has no valid word are skipped and do not use up any of that allowance. After the last word the writer pulses a completion output carrying the burst's word count. It then waits for the buffer-available flag to fall and rise again before it starts the next buffer.

The target must be set so that its warning flag falls when its free space reaches `TRAIL_WORDS + SYNC_STAGES` words. With the default parameters this is 4 words, and the target's buffer must be larger than that.

Top module: `wm_burst_writer`

## Requirements
- R1: While rst_ni is low and directly after reset, wr_n_o is 1, src_pop_o is 0 and done_o is 0.
- R2: In every cycle where wr_n_o is 0, data_o equals src_data_i and src_pop_o is 1. In every cycle where wr_n_o is 1, src_pop_o is 0. Words reach the bus in source order, one per clock.
- R3: No write happens while the registered buffer-available flag (ready_i, 1 = available) is low. A burst starts only when that flag is high and the registered warning flag is high.
- R4: wr_n_o stays 1 in any cycle where src_valid_i is 0. Such a cycle does not consume any of the words allowed after the warning.
- R5: From the first clock edge at which the raw warning flag wm_ni is low, the writer performs exactly TRAIL_WORDS + SYNC_STAGES writes, for any pattern of source stalls.
- R6: With the source always valid, exactly TRAIL_WORDS writes follow the clock edge at which the SYNC_STAGES-registered warning flag is first seen low.
- R7: Each burst delivers exactly the target's capacity, and no write is issued once the target is full.
- R8: done_o is a one-cycle pulse in the cycle after the last write of a burst. While done_o is 1, done_count_o equals the number of words in that burst and wr_n_o is 1.
- R9: After done_o the writer issues no write until the registered ready flag has been seen low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Target buffer available, 1 = can accept a burst |
| wm_ni | input | 1 | Target early-warning flag, active low |
| src_data_i | input | DATA_W | Word offered by the local source |
| src_valid_i | input | 1 | Source word valid |
| src_pop_o | output | 1 | Source word taken this cycle |
| wr_n_o | output | 1 | Bus write strobe, active low |
| data_o | output | DATA_W | Bus write data |
| done_o | output | 1 | Burst completion pulse |
| done_count_o | output | CNT_W | Words written in the burst just completed |

## Verification
The hardest corner is a source stall inside the flag-latency window or inside the drain. A writer that counted stalled cycles against the allowance, or that ignored in-flight writes, would fill the buffer short or write past its end. The bench catches this by checking the total number of writes after the raw warning falls, and by checking that the target is exactly full at completion. Buffers only one word larger than the warning level make the warning fall almost at once, which exposes a writer that starts its budget wrong. Long full-size buffers under both continuous and stalled flow catch off-by-one errors in the word count and in the drain count. Holding the ready flag low for varying gaps between buffers catches a writer that restarts on a stale ready flag.

// File: rtl/wmw_pkg.sv
package wmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_READY,
    ST_WRITE,
    ST_DRAIN,
    ST_DONE
  } wmw_state_e;
endpackage

// File: rtl/wmw_sync.sv
module wmw_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wmw_inflight.sv
// Counts strobes issued during the last DEPTH clock edges.
module wmw_inflight #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] count_o
);
  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q[0] <= 1'b0;
    else         hist_q[0] <= strobe_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[i] <= 1'b0;
      else         hist_q[i] <= hist_q[i-1];
    end
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < DEPTH; i++) count_o = count_o + CNT_W'(hist_q[i]);
  end
endmodule

// File: rtl/wmw_word_cnt.sv
module wmw_word_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (inc_i)   count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/wm_burst_writer.sv
module wm_burst_writer
  import wmw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int TRAIL_WORDS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              wm_ni,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_valid_i,
  output logic              src_pop_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  done_count_o
);
  // room left in target when its warning flag falls
  localparam int LEFT  = TRAIL_WORDS + SYNC_STAGES;
  localparam int REM_W = $clog2(LEFT + 1);

  wmw_state_e state_q, state_d;
  logic [REM_W-1:0] rem_q, rem_d, inflight, budget;
  logic ready_sync, wm_sync_n, wr_en;
  logic [CNT_W-1:0] word_cnt;

  wmw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wm_ni, ready_i}),
    .q_o   ({wm_sync_n, ready_sync})
  );

  wmw_inflight #(.DEPTH(SYNC_STAGES), .CNT_W(REM_W)) u_inflight (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(wr_en),
    .count_o (inflight)
  );

  wmw_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q == ST_WAIT_READY),
    .inc_i  (wr_en),
    .count_o(word_cnt)
  );

  assign budget = REM_W'(LEFT) - inflight;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    wr_en   = 1'b0;
    unique case (state_q)
      ST_IDLE:       if (!ready_sync) state_d = ST_WAIT_READY;
      ST_WAIT_READY: if (ready_sync && wm_sync_n) state_d = ST_WRITE;
      ST_WRITE: begin
        wr_en = src_valid_i;
        if (!wm_sync_n) begin
          rem_d   = budget - REM_W'(wr_en);
          state_d = (rem_d == '0) ? ST_DONE : ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        wr_en = src_valid_i;
        rem_d = rem_q - REM_W'(wr_en);
        if (rem_d == '0) state_d = ST_DONE;
      end
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_READY;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
    end
  end

  assign wr_n_o       = ~wr_en;
  assign src_pop_o    = wr_en;
  assign data_o       = src_data_i;
  assign done_o       = (state_q == ST_DONE);
  assign done_count_o = word_cnt;
endmodule

// File: rtl/wmw_checker.sv
module wmw_checker
  import wmw_pkg::*;
#(
  parameter int REM_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             src_valid_i,
  input logic             wr_n_o,
  input logic             done_o,
  input logic             ready_sync,
  input wmw_state_e       state_q,
  input logic [REM_W-1:0] rem_q
);
  a_r4_strobe_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> src_valid_i);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_quiet_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wr_n_o);

  a_r3_no_write_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_WAIT_READY) |-> wr_n_o);

  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ready_sync) |=> state_q == ST_IDLE);

  a_r5_drain_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DRAIN |-> rem_q != '0);

  a_r5_drain_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && !wr_n_o) |=> (state_q == ST_DONE || rem_q == $past(rem_q) - 1'b1));
endmodule

bind wm_burst_writer wmw_checker #(.REM_W(REM_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_valid_i(src_valid_i),
  .wr_n_o     (wr_n_o),
  .done_o     (done_o),
  .ready_sync (ready_sync),
  .state_q    (state_q),
  .rem_q      (rem_q)
);

// File: tb/sim_wm_burst_writer.sv
module sim_wm_burst_writer;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int TRAIL  = 2;
  localparam int SYNC   = 2;
  localparam int LEFT   = TRAIL + SYNC;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              ready, wm_n, src_valid, src_pop, wr_n, done;
  logic [DATA_W-1:0] src_data, data;
  logic [CNT_W-1:0]  done_count;

  int  n_checks = 0, n_errors = 0;
  int  free = 0, cap = 0, load_cap = 0, load_seq = 0, load_done = 0;
  bit  committed = 1'b1;
  int  burst_words = 0, after_raw = 0, after_sync = 0, stray = 0, dones = 0;
  int  valid_pct = 100, cycles = 0;
  bit  pend_wr = 1'b0;
  logic [DATA_W-1:0] pend_data, exp_word = '0;
  logic b1 = 1'b1, b2 = 1'b1;

  assign ready = !committed;
  assign wm_n  = (free > LEFT);

  wm_burst_writer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TRAIL_WORDS(TRAIL), .SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready), .wm_ni(wm_n),
    .src_data_i(src_data), .src_valid_i(src_valid), .src_pop_o(src_pop),
    .wr_n_o(wr_n), .data_o(data), .done_o(done), .done_count_o(done_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave FIFO model
  always @(posedge clk) begin
    b1 <= wm_n;
    b2 <= b1;
    if (load_seq != load_done) begin
      free <= load_cap; cap <= load_cap; committed <= 1'b0;
      burst_words <= 0; after_raw <= 0; after_sync <= 0;
      load_done <= load_seq;
    end else if (rst_n && pend_wr) begin
      if (free == 0 || committed) stray <= stray + 1;
      else begin
        free <= free - 1;
        if (free == 1) committed <= 1'b1;
      end
      if (pend_data != exp_word) stray <= stray + 1;
      exp_word    <= exp_word + 1;
      burst_words <= burst_words + 1;
      if (free <= LEFT) after_raw <= after_raw + 1;
      if (!b2) after_sync <= after_sync + 1;
    end
  end

  // source drive and bus sampling
  always @(negedge clk) begin
    src_valid = ($urandom_range(99) < valid_pct);
    #1;
    cycles++;
    if (rst_n) begin
      pend_wr   = !wr_n;
      pend_data = data;
      if (src_pop != pend_wr) chk(0, "R2 pop", src_pop, pend_wr);
      if (pend_wr && data != src_data) chk(0, "R2 data", data, src_data);
      if (pend_wr && !src_valid) chk(0, "R4 strobe without valid", 1, 0);
      if (pend_wr && committed) chk(0, "R3/R9 write while not ready", 1, 0);
      if (pend_wr) src_data = src_data + 1;
      if (done) begin
        dones++;
        chk(done_count == CNT_W'(cap), "R8 done count", done_count, cap);
        chk(burst_words == cap, "R7 burst length", burst_words, cap);
        chk(free == 0, "R7 target full at done", free, 0);
        chk(wr_n == 1'b1, "R8 strobe idle on done", wr_n, 1);
        chk(after_raw == LEFT, "R5 writes after raw warning", after_raw, LEFT);
        if (valid_pct == 100) chk(after_sync == TRAIL, "R6 trailing writes", after_sync, TRAIL);
        chk(stray == 0, "R7/R2 overrun or order", stray, 0);
      end
    end else pend_wr = 1'b0;
  end

  task automatic run_burst(input int c, input int pct, input int gap);
    int d0;
    d0 = dones;
    @(negedge clk);
    valid_pct = pct;
    load_cap  = c;
    load_seq++;
    wait (dones == d0 + 1);
    repeat (gap) @(negedge clk);
    chk(dones == d0 + 1 && stray == 0, "R9 quiet between buffers", dones - d0, 1);
  endtask

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    rst_n = 1'b0;
    src_data = '0;
    src_valid = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(wr_n == 1'b1, "R1 strobe in reset", wr_n, 1);
    chk(src_pop == 1'b0, "R1 pop in reset", src_pop, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(wr_n == 1'b1 && done == 1'b0, "R1 idle after reset", wr_n, 1);
    run_burst(4096, 100, 5);
    run_burst(4096, 60, 3);
    run_burst(LEFT + 1, 100, 4);
    run_burst(LEFT + 1, 30, 20);
    run_burst(LEFT + 2, 100, 3);
    run_burst(LEFT + 3, 50, 3);
    for (int i = 0; i < 10; i++) begin
      int c, p;
      c = $urandom_range(400, LEFT + 1);
      p = (i % 3 == 0) ? 100 : $urandom_range(99, 15);
      run_burst(c, p, $urandom_range(12, 3));
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule